// File: doc/BRIEF.md
# UART Echo Loopback Controller

This block sits between a UART receiver and a UART transmitter and returns every received byte to the sender. It does not connect the receiver's done pulse straight to the transmitter's start input. Received bytes go into a small queue, two slots deep by default. A start strobe is raised only while a byte is waiting and the transmitter reports that it is idle. When a byte arrives while an earlier one is still waiting, the controller still takes it in and raises a sticky overrun flag. A byte that arrives while the queue is full is discarded.

A mode select switches the transmit side to a test stream. In that mode the controller sends an incrementing byte value on every free transmitter slot. The value starts from zero and wraps after 0xFF. In both modes, four LED outputs follow the low nibble of the most recent received byte.

Top module: `uart_echo_ctrl`

## Requirements
- R1: In echo mode (testMode low), every byte accepted into the queue is presented on txData with a txStart pulse exactly once, unchanged and in arrival order.
- R2: txStart is high only in a cycle where txBusy is low. In echo mode it is high in the same cycle (combinationally) whenever at least one byte is queued and txBusy is low.
- R3: ledNibble equals bits 3..0 of rxData from the most recent cycle with rxValid high. It updates on the clock edge that samples rxValid, in either mode.
- R4: overrun goes high on the edge after an rxValid cycle in echo mode in which the queue already held at least one byte. It then stays high until reset.
- R5: In test mode, txStart is high whenever txBusy is low. txData carries a counter that starts at 0x00 and advances by one after each start, wrapping from 0xFF to 0x00.
- R6: In test mode, received bytes are not queued and are never echoed. They still update ledNibble.
- R7: During and directly after reset, no byte is queued, overrun is low, ledNibble is 0, and the first test-mode byte is 0x00.
- R8: A byte that arrives while the queue is full is accepted only if a start is issued in that same cycle. Otherwise it is dropped and the queued bytes are unchanged.
- R9: Bytes queued before a switch into test mode stay held, and they are echoed in order once echo mode resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxValid | input | 1 | One-cycle pulse: a received byte is on rxData |
| rxData | input | 8 | Received byte |
| txBusy | input | 1 | Transmitter is sending a frame |
| testMode | input | 1 | 1 = incrementing test stream, 0 = echo |
| txStart | output | 1 | Start strobe to the transmitter |
| txData | output | 8 | Byte to transmit, valid with txStart |
| ledNibble | output | 4 | Low nibble of the last received byte |
| overrun | output | 1 | Sticky flag: a byte arrived while another was queued |

## Verification
A bad occupancy count or a bad pointer shows up at the ports in one of three ways. A start strobe can appear while nothing is queued, an expected start can fail to appear, or a stale or reordered byte can appear on txData. Each of these shows in the first cycle the transmitter goes idle after the fault. A wrong test counter shows on the next test-mode start. A wrong LED or overrun register is visible one edge after the rxValid pulse that should have set it. The bench therefore compares every output against a behavioural model on every clock. Long busy periods fill the queue and force drops, and a run of more than 256 test frames crosses the counter wrap.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic push;     // write rxData into the queue tail
    logic pop;      // retire the queue head
    logic ledLoad;  // capture the received nibble
    logic testAdv;  // advance the test counter
  } ctrlStrobes_t;
endpackage

// File: rtl/uart_echo_ctrl_fsm.sv
module uart_echo_ctrl_fsm
  import uart_echo_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxValid,
  input  logic         txBusy,
  input  logic         testMode,
  output ctrlStrobes_t strobes,
  output logic         txStart,
  output logic         selTest,
  output logic         overrun
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] fillCnt;
  logic             haveByte;
  logic             popNow;
  logic             pushNow;

  assign haveByte = (fillCnt != '0);
  assign popNow   = !testMode && haveByte && !txBusy;
  assign pushNow  = rxValid && !testMode && ((fillCnt != FULL_CNT) || popNow);

  assign txStart  = testMode ? !txBusy : popNow;
  assign selTest  = testMode;

  always_comb begin
    strobes         = '0;
    strobes.push    = pushNow;
    strobes.pop     = popNow;
    strobes.ledLoad = rxValid;
    strobes.testAdv = testMode && !txBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
      overrun <= 1'b0;
    end else begin
      case ({pushNow, popNow})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
      if (rxValid && !testMode && haveByte)
        overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_echo_datapath.sv
module uart_echo_datapath
  import uart_echo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LED_W  = 4,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              selTest,
  input  logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] txData,
  output logic [LED_W-1:0]  ledNibble
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] slotMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [DATA_W-1:0] testCnt;
  logic [LED_W-1:0]  ledReg;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobes.push && (wrPtr == PTR_W'(s)))
        slotMem[s] <= rxData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      testCnt <= '0;
      ledReg  <= '0;
    end else begin
      if (strobes.push)
        wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
      if (strobes.pop)
        rdPtr <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
      if (strobes.testAdv)
        testCnt <= testCnt + 1'b1;
      if (strobes.ledLoad)
        ledReg <= rxData[LED_W-1:0];
    end
  end

  assign txData    = selTest ? testCnt : slotMem[rdPtr];
  assign ledNibble = ledReg;
endmodule

// File: rtl/uart_echo_ctrl.sv
module uart_echo_ctrl
  import uart_echo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LED_W  = 4,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              txBusy,
  input  logic              testMode,
  output logic              txStart,
  output logic [DATA_W-1:0] txData,
  output logic [LED_W-1:0]  ledNibble,
  output logic              overrun
);
  ctrlStrobes_t strobes;
  logic         selTest;

  uart_echo_ctrl_fsm #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .txBusy(txBusy),
    .testMode(testMode), .strobes(strobes), .txStart(txStart),
    .selTest(selTest), .overrun(overrun)
  );

  uart_echo_datapath #(.DATA_W(DATA_W), .LED_W(LED_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selTest(selTest),
    .rxData(rxData), .txData(txData), .ledNibble(ledNibble)
  );
endmodule

// File: rtl/uart_echo_ctrl_checker.sv
module uart_echo_ctrl_checker #(
  parameter int DATA_W = 8,
  parameter int LED_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxData,
  input logic              txBusy,
  input logic              testMode,
  input logic              txStart,
  input logic [DATA_W-1:0] txData,
  input logic [LED_W-1:0]  ledNibble,
  input logic              overrun
);
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> !txBusy);

  assert_led_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> ledNibble == $past(rxData[LED_W-1:0]));

  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  assert_overrun_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxValid) && !$past(testMode));

  assert_test_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && txStart) ##1 (testMode && txStart)
      |-> txData == $past(txData) + 1'b1);

  assert_test_always_R5: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && !txBusy) |-> txStart);
endmodule

bind uart_echo_ctrl uart_echo_ctrl_checker #(.DATA_W(DATA_W), .LED_W(LED_W)) u_checker (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .txBusy(txBusy),
  .testMode(testMode), .txStart(txStart), .txData(txData),
  .ledNibble(ledNibble), .overrun(overrun)
);

// File: tb/uart_echo_ctrl_bench.sv
module uart_echo_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic       txBusy;
  logic       testMode = 1'b0;
  logic       txStart;
  logic [7:0] txData;
  logic [3:0] ledNibble;
  logic       overrun;

  int compared = 0;
  int mismatched = 0;
  int busyLen = 3;
  int busyCnt = 0;
  int cycles = 0;

  // behavioural model state
  int mQ[$];
  int mCnt = 0;
  int mLed = 0;
  bit mOv = 0;
  int echoed = 0;
  int dropped = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_echo_ctrl u_uart_echo_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .txBusy(txBusy),
    .testMode(testMode), .txStart(txStart), .txData(txData),
    .ledNibble(ledNibble), .overrun(overrun)
  );

  // transmitter stand-in: busy for busyLen cycles after each start
  assign txBusy = (busyCnt != 0);
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) busyCnt <= 0;
    else if (busyCnt > 0) busyCnt <= busyCnt - 1;
    else if (txStart) busyCnt <= busyLen;
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // one clock: compare registered outputs, drive inputs, compare combinational outputs, advance model
  task automatic step(input bit rv, input int rd, input bit tm);
    bit expStart, pop, push;
    int expData;
    @(negedge clk);
    chk("R3 ledNibble", int'(ledNibble), mLed);
    chk("R4 overrun", int'(overrun), int'(mOv));
    rxValid = rv; rxData = rd[7:0]; testMode = tm;
    #1;
    chk("R2 start only when idle", int'(txStart && txBusy), 0);
    expStart = tm ? !txBusy : (mQ.size() > 0 && !txBusy);
    chk(tm ? "R5 test txStart" : "R2 R9 echo txStart", int'(txStart), int'(expStart));
    if (expStart && txStart) begin
      expData = tm ? mCnt : mQ[0];
      chk(tm ? "R5 test txData" : "R1 R6 R8 echo txData", int'(txData), expData);
    end
    pop  = expStart && !tm;
    push = rv && !tm && (mQ.size() < DEPTH || pop);
    if (rv && !tm && mQ.size() > 0) mOv = 1;
    if (rv && !tm && !push) dropped++;
    if (rv) mLed = rd & 4'hF;
    if (expStart && tm) mCnt = (mCnt + 1) & 8'hFF;
    if (pop) begin void'(mQ.pop_front()); echoed++; end
    if (push) mQ.push_back(rd & 8'hFF);
  endtask

  task automatic idle(input int n, input bit tm);
    for (int i = 0; i < n; i++) step(1'b0, 0, tm);
  endtask

  task automatic finishRun;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired, actual=running expected=done");
    finishRun();
  end

  initial begin
    // R7: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset txStart", int'(txStart), 0);
    chk("R7 reset overrun", int'(overrun), 0);
    chk("R7 reset ledNibble", int'(ledNibble), 0);
    rstN = 1'b1;
    idle(2, 1'b0);
    chk("R7 no queued byte after reset", int'(txStart), 0);

    // R1: spaced bytes echoed in order
    busyLen = 3;
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 8'h30 + i * 7, 1'b0);
      idle(8, 1'b0);
    end
    chk("R4 no overrun with spaced bytes", int'(overrun), 0);

    // R4 R8: slow transmitter, back-to-back arrivals fill queue and drop
    busyLen = 20;
    step(1'b1, 8'hA1, 1'b0);
    step(1'b1, 8'hB2, 1'b0);
    step(1'b1, 8'hC3, 1'b0);
    step(1'b1, 8'hD4, 1'b0);
    idle(4, 1'b0);
    step(1'b1, 8'hE5, 1'b0);
    idle(80, 1'b0);
    chk("R8 bytes dropped when full", int'(dropped > 0), 1);

    // R8: arrival while full on the cycle a start is issued
    busyLen = 6;
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 8'h50 + i, 1'b0);
      idle(2 + (i % 4), 1'b0);
    end
    idle(60, 1'b0);

    // R9: bytes held across test mode
    busyLen = 15;
    step(1'b1, 8'h11, 1'b0);
    step(1'b1, 8'h22, 1'b0);
    step(1'b1, 8'h33, 1'b0);
    idle(1, 1'b0);

    // R5 R6: test stream across the wrap, received bytes ignored for echo
    busyLen = 2;
    for (int i = 0; i < 1000; i++) begin
      if (i % 37 == 5) step(1'b1, 8'h70 + i, 1'b1);
      else step(1'b0, 0, 1'b1);
    end
    chk("R5 counter wrapped past 0xFF", int'(mCnt < 100), 1);

    // back to echo: held bytes drain, nothing from test mode appears
    idle(60, 1'b0);
    step(1'b1, 8'h9C, 1'b0);
    idle(20, 1'b0);
    chk("R1 R6 queue drained", mQ.size(), 0);
    chk("R1 echo count nonzero", int'(echoed > 10), 1);
    finishRun();
  end
endmodule